// File: doc/BRIEF.md
# Loadable Up/Down Wiper Position Register

This block holds the tap position of one digitally controlled potentiometer channel as an 8-bit code. It also drives a 256-wide select vector in which exactly one bit is set, so one resistor-array switch is closed at any time. Code 00h picks the low end of the array and FFh the high end. The array and its analog behaviour lie outside the block.

The position can change in four ways. A host write loads a byte directly. A transfer copies one of the channel's four stored data registers, which are presented on a flat input bus. In step mode, each rising edge of a synchronised serial-clock level moves the wiper by one tap, with the serial-data level setting the direction. While reset is held, the register tracks data register 0, so it leaves reset holding the recalled setting and not any earlier value.

All load strobes are plain control pins. Each one is accepted in the cycle it is sampled, and there is no back-pressure. The step inputs must already be synchronous to `clk`.

Top module: `wiper_position_reg`

## Requirements
- R1: While `rst_n` is low, `pos` takes `dr_bank[7:0]` (data register 0) at every clock edge, and the first cycle after reset starts from that value.
- R2: Except before the first clock edge, `tap_sel` has exactly one bit set. Bit 0 corresponds to code 00h (low terminal) and bit 255 to code FFh (high terminal).
- R3: `tap_sel` is registered. Its set bit equals the value `pos` held one clock earlier; during reset it equals the recalled data register 0 value.
- R4: When `host_wr_en` is high at a clock edge, `pos` equals `host_wr_data` after that edge.
- R5: When `xfer_en` is high and `host_wr_en` is low, `pos` loads `dr_bank[8*xfer_sel +: 8]` at that edge.
- R6: When `step_mode` is high and `step_clk` is high at an edge where it was low at the previous edge, and `step_dir` is 1, `pos` increases by one.
- R7: The same step edge with `step_dir` 0 decreases `pos` by one.
- R8: Stepping saturates: an increase at FFh or a decrease at 00h leaves `pos` unchanged.
- R9: A `step_clk` high level held for several cycles produces only one step. A `step_clk` already high when reset is released counts as no edge.
- R10: With `step_mode` low, `step_clk` pulses leave `pos` unchanged.
- R11: Priority is host write, then transfer, then step. A lower-priority request in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; while low, data register 0 is recalled |
| dr_bank | input | 32 | Four stored data registers, register k in bits 8k+7..8k |
| host_wr_en | input | 1 | Direct host write strobe |
| host_wr_data | input | 8 | Direct host write value |
| xfer_en | input | 1 | Parallel transfer strobe |
| xfer_sel | input | 2 | Data register chosen for a transfer |
| step_mode | input | 1 | Enables single-tap stepping |
| step_clk | input | 1 | Synchronised step clock level; its rising edge is one step |
| step_dir | input | 1 | 1 = toward high terminal, 0 = toward low terminal |
| pos | output | 8 | Registered wiper code |
| tap_sel | output | 256 | Registered one-hot switch select |

## Verification
Every load, and every qualified `step_clk` rising edge, changes `pos` on the same clock edge at which it is sampled. `tap_sel` follows one edge later. The bench drives inputs on the falling edge and advances a behavioural model by one step per cycle from the values it drove. After the next rising edge it compares both outputs on the falling edge, so each output is checked in exactly the cycle it is due. The stimulus covers held step levels, saturation at both ends, requests that collide in one cycle, and a reset in the middle of the run.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam int unsigned DEF_POS_W  = 8;
  localparam int unsigned DEF_NUM_DR = 4;

  // Which source wins the next-position selection in a cycle.
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_HOST = 2'd1,
    SRC_XFER = 2'd2,
    SRC_STEP = 2'd3
  } pos_src_e;
endpackage

// File: rtl/wiper_step_detect.sv
module wiper_step_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic step_mode,
  input  logic step_clk,
  output logic step_fire
);
  logic level_q;

  // The previous level resets high, so a level already high when reset is released is not an edge.
  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b1;
    else        level_q <= step_clk;
  end

  assign step_fire = step_mode & step_clk & ~level_q;
endmodule

// File: rtl/wiper_next_pos.sv
module wiper_next_pos
  import wiper_pkg::*;
#(
  parameter int unsigned POS_W  = DEF_POS_W,
  parameter int unsigned NUM_DR = DEF_NUM_DR,
  localparam int unsigned SEL_W = (NUM_DR > 1) ? $clog2(NUM_DR) : 1
) (
  input  logic [POS_W-1:0]        cur_pos,
  input  logic [NUM_DR*POS_W-1:0] dr_bank,
  input  logic                    host_wr_en,
  input  logic [POS_W-1:0]        host_wr_data,
  input  logic                    xfer_en,
  input  logic [SEL_W-1:0]        xfer_sel,
  input  logic                    step_fire,
  input  logic                    step_dir,
  output logic [POS_W-1:0]        nxt_pos
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_MIN = '0;

  pos_src_e         src;
  logic [POS_W-1:0] xfer_val;
  logic [POS_W-1:0] step_val;

  always_comb begin
    xfer_val = '0;
    for (int k = 0; k < NUM_DR; k++) begin
      if (xfer_sel == SEL_W'(k)) xfer_val = dr_bank[k*POS_W +: POS_W];
    end
  end

  always_comb begin
    step_val = cur_pos;
    if (step_dir) begin
      if (cur_pos != POS_MAX) step_val = cur_pos + 1'b1;
    end else begin
      if (cur_pos != POS_MIN) step_val = cur_pos - 1'b1;
    end
  end

  always_comb begin
    if (host_wr_en)     src = SRC_HOST;
    else if (xfer_en)   src = SRC_XFER;
    else if (step_fire) src = SRC_STEP;
    else                src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_HOST: nxt_pos = host_wr_data;
      SRC_XFER: nxt_pos = xfer_val;
      SRC_STEP: nxt_pos = step_val;
      default:  nxt_pos = cur_pos;
    endcase
  end
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
  parameter int unsigned POS_W = 8,
  localparam int unsigned TAPS = 1 << POS_W
) (
  input  logic             clk,
  input  logic [POS_W-1:0] code,
  output logic [TAPS-1:0]  tap_q
);
  logic [TAPS-1:0] dec;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign dec[i] = (code == POS_W'(i));
  end

  always_ff @(posedge clk) begin
    tap_q <= dec;
  end
endmodule

// File: rtl/wiper_position_reg.sv
module wiper_position_reg
  import wiper_pkg::*;
#(
  parameter int unsigned POS_W  = DEF_POS_W,
  parameter int unsigned NUM_DR = DEF_NUM_DR,
  localparam int unsigned SEL_W = (NUM_DR > 1) ? $clog2(NUM_DR) : 1,
  localparam int unsigned TAPS  = 1 << POS_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_DR*POS_W-1:0] dr_bank,
  input  logic                    host_wr_en,
  input  logic [POS_W-1:0]        host_wr_data,
  input  logic                    xfer_en,
  input  logic [SEL_W-1:0]        xfer_sel,
  input  logic                    step_mode,
  input  logic                    step_clk,
  input  logic                    step_dir,
  output logic [POS_W-1:0]        pos,
  output logic [TAPS-1:0]         tap_sel
);
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] nxt_pos;
  logic [POS_W-1:0] recall_val;
  logic [POS_W-1:0] dec_src;
  logic             step_fire;

  assign recall_val = dr_bank[POS_W-1:0];

  wiper_step_detect u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_mode (step_mode),
    .step_clk  (step_clk),
    .step_fire (step_fire)
  );

  wiper_next_pos #(
    .POS_W  (POS_W),
    .NUM_DR (NUM_DR)
  ) u_next (
    .cur_pos      (pos_q),
    .dr_bank      (dr_bank),
    .host_wr_en   (host_wr_en),
    .host_wr_data (host_wr_data),
    .xfer_en      (xfer_en),
    .xfer_sel     (xfer_sel),
    .step_fire    (step_fire),
    .step_dir     (step_dir),
    .nxt_pos      (nxt_pos)
  );

  // Reset recalls data register 0 into the volatile position.
  always_ff @(posedge clk) begin
    if (!rst_n) pos_q <= recall_val;
    else        pos_q <= nxt_pos;
  end

  // During reset the decoder sees the recalled code, so the select is one-hot from the first edge.
  assign dec_src = rst_n ? pos_q : recall_val;

  wiper_tap_decode #(.POS_W(POS_W)) u_dec (
    .clk   (clk),
    .code  (dec_src),
    .tap_q (tap_sel)
  );

  assign pos = pos_q;
endmodule

// File: rtl/wiper_position_chk.sv
module wiper_position_chk #(
  parameter int unsigned POS_W = 8,
  localparam int unsigned TAPS = 1 << POS_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr_en,
  input logic [POS_W-1:0] host_wr_data,
  input logic             xfer_en,
  input logic             step_mode,
  input logic             step_dir,
  input logic [POS_W-1:0] pos,
  input logic [TAPS-1:0]  tap_sel
);
  localparam logic [POS_W-1:0] PMAX = {POS_W{1'b1}};

  // R2
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);

  // R3
  tap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> tap_sel[$past(pos)]);

  // R4
  host_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_en |=> pos == $past(host_wr_data));

  // R8
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == PMAX && step_mode && step_dir && !host_wr_en && !xfer_en) |=> pos == PMAX);

  // R8
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == '0 && step_mode && !step_dir && !host_wr_en && !xfer_en) |=> pos == '0);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr_en && !xfer_en && !step_mode) |=> $stable(pos));
endmodule

bind wiper_position_reg wiper_position_chk #(.POS_W(POS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_wr_en   (host_wr_en),
  .host_wr_data (host_wr_data),
  .xfer_en      (xfer_en),
  .step_mode    (step_mode),
  .step_dir     (step_dir),
  .pos          (pos),
  .tap_sel      (tap_sel)
);

// File: tb/wiper_position_reg_test.sv
module wiper_position_reg_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [31:0]  dr_bank;
  logic         host_wr_en;
  logic [7:0]   host_wr_data;
  logic         xfer_en;
  logic [1:0]   xfer_sel;
  logic         step_mode;
  logic         step_clk;
  logic         step_dir;
  logic [7:0]   pos;
  logic [255:0] tap_sel;

  int n_run  = 0;
  int n_fail = 0;
  int m_pos, m_tap, m_prev;
  string cur_req = "R1";

  always #5 clk = ~clk;

  wiper_position_reg uut (
    .clk(clk), .rst_n(rst_n), .dr_bank(dr_bank),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .xfer_en(xfer_en), .xfer_sel(xfer_sel),
    .step_mode(step_mode), .step_clk(step_clk), .step_dir(step_dir),
    .pos(pos), .tap_sel(tap_sel)
  );

  // One clock: advance the model from the driven inputs, then compare on the falling edge.
  task automatic cyc();
    int edge_seen;
    if (!rst_n) begin
      m_pos  = int'(dr_bank[7:0]);
      m_tap  = m_pos;
      m_prev = 1;
    end else begin
      m_tap     = m_pos;
      edge_seen = (step_clk && !m_prev) ? 1 : 0;
      m_prev    = int'(step_clk);
      if (host_wr_en)   m_pos = int'(host_wr_data);
      else if (xfer_en) m_pos = int'(dr_bank[xfer_sel*8 +: 8]);
      else if (step_mode && edge_seen == 1) begin
        if (step_dir) begin if (m_pos < 255) m_pos++; end
        else          begin if (m_pos > 0)   m_pos--; end
      end
    end
    @(posedge clk);
    @(negedge clk);
    n_run++;
    if (int'(pos) != m_pos) begin
      n_fail++;
      $display("FAIL %s pos: got %0d expected %0d", cur_req, pos, m_pos);
    end
    n_run++;
    if (tap_sel !== (256'(1) << m_tap)) begin
      n_fail++;
      $display("FAIL R2/R3 tap_sel: got set bits %0d low word %h expected bit %0d",
               $countones(tap_sel), tap_sel[31:0], m_tap);
    end
  endtask

  task automatic pulse(input logic dir, input int hold);
    step_dir = dir;
    step_clk = 1'b1;
    repeat (hold) cyc();
    step_clk = 1'b0;
    cyc();
    cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dr_bank = 32'hC4_19_A2_37;
    host_wr_en = 0; host_wr_data = 0; xfer_en = 0; xfer_sel = 0;
    step_mode = 0; step_clk = 0; step_dir = 0;
    @(negedge clk);
    cur_req = "R1"; repeat (3) cyc();
    rst_n = 1'b1; cyc(); cyc();

    cur_req = "R4";
    host_wr_en = 1; host_wr_data = 8'h80; cyc();
    host_wr_en = 0; cyc();

    cur_req = "R5";
    xfer_en = 1; xfer_sel = 2; cyc();
    xfer_en = 0; cyc();
    xfer_en = 1; xfer_sel = 3; cyc();
    xfer_en = 0; cyc();

    cur_req = "R6"; step_mode = 1;
    repeat (3) pulse(1'b1, 2);
    cur_req = "R7";
    repeat (5) pulse(1'b0, 1);

    cur_req = "R8";
    host_wr_en = 1; host_wr_data = 8'hFE; cyc(); host_wr_en = 0;
    repeat (3) pulse(1'b1, 1);
    host_wr_en = 1; host_wr_data = 8'h01; cyc(); host_wr_en = 0;
    repeat (3) pulse(1'b0, 1);

    cur_req = "R9";
    host_wr_en = 1; host_wr_data = 8'h40; cyc(); host_wr_en = 0;
    pulse(1'b1, 6);
    pulse(1'b0, 4);

    cur_req = "R10"; step_mode = 0;
    repeat (3) pulse(1'b1, 1);
    repeat (3) pulse(1'b0, 2);
    step_mode = 1;

    cur_req = "R11";
    host_wr_en = 1; host_wr_data = 8'h11; xfer_en = 1; xfer_sel = 1; cyc();
    host_wr_en = 0; xfer_en = 0; cyc();
    xfer_en = 1; xfer_sel = 1; step_dir = 1; step_clk = 1; cyc();
    xfer_en = 0; cyc(); step_clk = 0; cyc();
    host_wr_en = 1; host_wr_data = 8'h05; step_dir = 0; step_clk = 1; cyc();
    host_wr_en = 0; cyc(); step_clk = 0; cyc();

    cur_req = "R1";
    dr_bank = 32'h01_02_03_E9; step_clk = 1; rst_n = 0; cyc(); cyc();
    rst_n = 1; cyc();
    cur_req = "R9"; cyc(); step_clk = 0; cyc();

    cur_req = "R6";
    for (int i = 0; i < 300; i++) begin
      host_wr_en   = ($urandom_range(0, 15) == 0);
      host_wr_data = 8'($urandom);
      xfer_en      = ($urandom_range(0, 15) == 0);
      xfer_sel     = 2'($urandom);
      step_mode    = ($urandom_range(0, 7) != 0);
      step_clk     = 1'($urandom);
      step_dir     = 1'($urandom);
      dr_bank      = $urandom;
      cyc();
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule